// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between a host write port and the embedded program and erase engines of a byte-wide flash macro. It watches single-cycle write strobes carrying a 19-bit byte address and an 8-bit data value. Every operation must be preceded by a fixed two-write unlock handshake and a command code. The decoder turns a complete, well-formed sequence into a one-cycle request to the engine, together with the latched address and data or a mask of the sectors to erase. It also reports which mode the device is in, so that the read path can choose between array data, identifier bytes and engine status.

Writes are checked only on their low 11 address bits during the unlock and command steps. Any write that does not fit the expected step sends the decoder back to array-read mode. A sector erase collects a list of sectors, one at a time. Each new sector must arrive inside a timed window that is restarted by every accepted sector. When the window runs out with no write, the erase request is issued. While an engine runs, the decoder accepts only the narrow set of writes that the running operation allows. The engine reports back through a completion input and a timeout-failure input.

States, each named by its role: `S_READ` (idle, array read), `S_UNL1` (first key seen), `S_UNL2` (second key seen, command expected), `S_PGM_SETUP` (program address and data expected), `S_ERA_UNL0` and `S_ERA_UNL1` (second pair of keys for erase), `S_ERA_CMD` (chip or sector erase code expected), `S_SECT_WIN` (sector collection window open), `S_PROGRAM` and `S_ERASE` (engine running), `S_SUSPEND` (erase held), `S_IDENT` (identifier mode) and `S_FAIL` (engine timed out).

The transitions are as follows:
- key A moves `S_READ` to `S_UNL1`.
- key B moves `S_UNL1` to `S_UNL2`.
- code A0h moves `S_UNL2` to `S_PGM_SETUP`, code 80h moves it to `S_ERA_UNL0`, and code 90h moves it to `S_IDENT`.
- any data write moves `S_PGM_SETUP` to `S_PROGRAM`.
- key A moves `S_ERA_UNL0` to `S_ERA_UNL1`, and key B moves `S_ERA_UNL1` to `S_ERA_CMD`.
- code 10h moves `S_ERA_CMD` to `S_ERASE`, and code 30h moves it to `S_SECT_WIN`.
- window expiry moves `S_SECT_WIN` to `S_ERASE`.
- code B0h moves `S_ERASE` to `S_SUSPEND`, and code 30h moves `S_SUSPEND` back to `S_ERASE`.
- completion moves `S_PROGRAM` or `S_ERASE` to `S_READ`, and failure moves them to `S_FAIL`.
- F0h moves `S_IDENT` or `S_FAIL` to `S_READ`.
- any mismatch in a sequence state moves it to `S_READ`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode_read is 1 and mode_id, busy, suspended, win_open, every request output and sect_mask are 0. Exactly one of mode_read, mode_id, busy, suspended and win_open is 1 at any time.
- R2: The byte program sequence is written as four writes: AAh with low address bits 555h, then 55h with low bits 2AAh, then A0h with low bits 555h, then one write of any address and data. In the cycle after the fourth write, pgm_req pulses for one cycle with pgm_addr and pgm_data holding that write, and busy is 1. Address bits above bit 10 are ignored in the unlock and command writes.
- R3: The chip erase sequence is the two keys, 80h at 555h, the two keys again, then 10h at 555h. In the cycle after the last write, chip_erase_req pulses, sect_mask is all ones and busy is 1.
- R4: The sector erase sequence is the two keys, 80h at 555h, the two keys again, then 30h at any address. This opens the window (win_open=1) and sets sect_mask bit addr[18:16]. sect_mask is cleared whenever 80h is accepted.
- R5: During the window, a 30h write adds its sector and restarts the window. A write at the WIN_CYCLES-th edge after the previous sector is still accepted. A B0h write during the window is ignored and does not restart it. WIN_CYCLES edges after the last sector with no write, sect_erase_req pulses and busy rises.
- R6: During the window, any write other than 30h or B0h closes the window and returns to mode_read, and no erase request follows.
- R7: The identifier sequence is the two keys then 90h at 555h, and it sets mode_id. With id_sel[1]=0, id_byte is C2h when id_sel[0]=0 and 4Fh when id_sel[0]=1. Otherwise, and outside identifier mode, id_byte is 00h. In identifier mode, only F0h has an effect, and it returns to mode_read.
- R8: A wrong address or data at any unlock or command step returns to mode_read. F0h written in place of the program data write also returns to mode_read. Either way, no request is made.
- R9: While a program runs, every write, including F0h, is ignored, and pgm_addr and pgm_data hold their values. op_done returns the decoder to mode_read.
- R10: While an erase runs, only B0h has an effect: it sets suspended. While suspended, only 30h has an effect: it resumes the erase (busy=1).
- R11: If op_done and a B0h write arrive in the same cycle during an erase, completion wins and the decoder returns to mode_read. op_done is ignored while suspended.
- R12: op_fail during a program or erase keeps busy at 1. After that, only F0h has an effect, and it returns to mode_read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 19 | Write byte address |
| wr_data | input | 8 | Write data |
| id_sel | input | 2 | Low two read-address bits for identifier reads |
| op_done | input | 1 | Engine finished successfully |
| op_fail | input | 1 | Engine exceeded its time limit |
| pgm_req | output | 1 | One-cycle byte program request |
| pgm_addr | output | 19 | Latched program address |
| pgm_data | output | 8 | Latched program data |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| sect_mask | output | 8 | Sectors selected for erase |
| win_open | output | 1 | Sector collection window open |
| mode_read | output | 1 | Array-read mode, including partial sequences |
| mode_id | output | 1 | Identifier mode |
| busy | output | 1 | Engine running or failed |
| suspended | output | 1 | Erase held |
| id_byte | output | 8 | Identifier value for the current id_sel |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a write arriving on the last window edge and the window running out. The bench places a 30h write exactly WIN_CYCLES edges after the previous sector and expects the sector to be added and the window to stay open. It also places a B0h write just after a load and expects the expiry edge to stay where it was. The second pair is engine completion and a suspend write arriving together. The bench drives op_done and B0h in one cycle and judges that the decoder reads as idle rather than suspended.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PGM_SETUP,
        S_ERA_UNL0,
        S_ERA_UNL1,
        S_ERA_CMD,
        S_SECT_WIN,
        S_PROGRAM,
        S_ERASE,
        S_SUSPEND,
        S_IDENT,
        S_FAIL
    } fcd_state_e;

    localparam int          KEY_BITS      = 11;
    localparam logic [10:0] KEY_ADDR_A    = 11'h555;
    localparam logic [10:0] KEY_ADDR_B    = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A    = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B    = 8'h55;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]  OP_ERASE_SET  = 8'h80;
    localparam logic [7:0]  OP_IDENT      = 8'h90;
    localparam logic [7:0]  OP_RESET      = 8'hF0;
    localparam logic [7:0]  OP_CHIP       = 8'h10;
    localparam logic [7:0]  OP_SECTOR     = 8'h30;
    localparam logic [7:0]  OP_SUSPEND    = 8'hB0;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import fcd_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output logic          key_a,
    output logic          key_b,
    output logic          cmd_slot
);
    logic [KEY_BITS-1:0] low;

    assign low      = addr[KEY_BITS-1:0];
    assign cmd_slot = (low == KEY_ADDR_A);
    assign key_a    = cmd_slot && (data == KEY_DATA_A);
    assign key_b    = (low == KEY_ADDR_B) && (data == KEY_DATA_B);
endmodule

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
    parameter int WIN_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic at_zero
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(WIN_CYCLES - 1);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);
endmodule

// File: rtl/fcd_sector_mask.sv
module fcd_sector_mask #(
    parameter int AW = 19,
    parameter int NS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          fill,
    input  logic          add,
    input  logic [AW-1:0] addr,
    output logic [NS-1:0] mask
);
    localparam int SW = $clog2(NS);

    logic [SW-1:0] sel;
    assign sel = addr[AW-1 -: SW];

    for (genvar i = 0; i < NS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask[i] <= 1'b0;
            else if (clear)
                mask[i] <= 1'b0;
            else if (fill)
                mask[i] <= 1'b1;
            else if (add && sel == SW'(i))
                mask[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int          AW         = 19,
    parameter int          NS         = 8,
    parameter int          WIN_CYCLES = 5000,
    parameter logic [7:0]  MFR_CODE   = 8'hC2,
    parameter logic [7:0]  DEV_CODE   = 8'h4F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    id_sel,
    input  logic          op_done,
    input  logic          op_fail,
    output logic          pgm_req,
    output logic [AW-1:0] pgm_addr,
    output logic [7:0]    pgm_data,
    output logic          chip_erase_req,
    output logic          sect_erase_req,
    output logic [NS-1:0] sect_mask,
    output logic          win_open,
    output logic          mode_read,
    output logic          mode_id,
    output logic          busy,
    output logic          suspended,
    output logic [7:0]    id_byte
);
    fcd_state_e state, nxt;

    logic key_a, key_b, cmd_slot;
    logic mask_clr, mask_fill, mask_add, tmr_load, tmr_zero;
    logic pgm_go, chip_go, sect_go;

    fcd_cycle_match #(.AW(AW)) u_match (
        .addr     (wr_addr),
        .data     (wr_data),
        .key_a    (key_a),
        .key_b    (key_b),
        .cmd_slot (cmd_slot)
    );

    fcd_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (state == S_SECT_WIN),
        .at_zero (tmr_zero)
    );

    fcd_sector_mask #(.AW(AW), .NS(NS)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mask_clr),
        .fill  (mask_fill),
        .add   (mask_add),
        .addr  (wr_addr),
        .mask  (sect_mask)
    );

    // Next-state decode
    always_comb begin
        nxt       = state;
        mask_clr  = 1'b0;
        mask_fill = 1'b0;
        mask_add  = 1'b0;
        tmr_load  = 1'b0;
        pgm_go    = 1'b0;
        chip_go   = 1'b0;
        sect_go   = 1'b0;
        unique case (state)
            S_READ:
                if (wr_en && key_a) nxt = S_UNL1;
            S_UNL1:
                if (wr_en) nxt = key_b ? S_UNL2 : S_READ;
            S_UNL2:
                if (wr_en) begin
                    nxt = S_READ;
                    if (cmd_slot) begin
                        case (wr_data)
                            OP_PROGRAM:   nxt = S_PGM_SETUP;
                            OP_ERASE_SET: begin
                                nxt      = S_ERA_UNL0;
                                mask_clr = 1'b1;
                            end
                            OP_IDENT:     nxt = S_IDENT;
                            default:      nxt = S_READ;
                        endcase
                    end
                end
            S_PGM_SETUP:
                if (wr_en) begin
                    if (wr_data == OP_RESET) begin
                        nxt = S_READ;
                    end else begin
                        nxt    = S_PROGRAM;
                        pgm_go = 1'b1;
                    end
                end
            S_ERA_UNL0:
                if (wr_en) nxt = key_a ? S_ERA_UNL1 : S_READ;
            S_ERA_UNL1:
                if (wr_en) nxt = key_b ? S_ERA_CMD : S_READ;
            S_ERA_CMD:
                if (wr_en) begin
                    if (cmd_slot && wr_data == OP_CHIP) begin
                        nxt       = S_ERASE;
                        mask_fill = 1'b1;
                        chip_go   = 1'b1;
                    end else if (wr_data == OP_SECTOR) begin
                        nxt      = S_SECT_WIN;
                        mask_add = 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        nxt = S_READ;
                    end
                end
            S_SECT_WIN:
                if (wr_en) begin
                    if (wr_data == OP_SECTOR) begin
                        mask_add = 1'b1;
                        tmr_load = 1'b1;
                    end else if (wr_data != OP_SUSPEND) begin
                        nxt = S_READ;
                    end
                end else if (tmr_zero) begin
                    nxt     = S_ERASE;
                    sect_go = 1'b1;
                end
            S_PROGRAM:
                if (op_fail)      nxt = S_FAIL;
                else if (op_done) nxt = S_READ;
            S_ERASE:
                if (op_fail)      nxt = S_FAIL;
                else if (op_done) nxt = S_READ;
                else if (wr_en && wr_data == OP_SUSPEND) nxt = S_SUSPEND;
            S_SUSPEND:
                if (wr_en && wr_data == OP_SECTOR) nxt = S_ERASE;
            S_IDENT, S_FAIL:
                if (wr_en && wr_data == OP_RESET) nxt = S_READ;
            default:
                nxt = S_READ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_READ;
        else        state <= nxt;
    end

    // Registered request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_req        <= 1'b0;
            chip_erase_req <= 1'b0;
            sect_erase_req <= 1'b0;
            pgm_addr       <= '0;
            pgm_data       <= '0;
        end else begin
            pgm_req        <= pgm_go;
            chip_erase_req <= chip_go;
            sect_erase_req <= sect_go;
            if (pgm_go) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
        end
    end

    // Mode flags and identifier read
    always_comb begin
        mode_id   = (state == S_IDENT);
        busy      = (state == S_PROGRAM) || (state == S_ERASE) || (state == S_FAIL);
        suspended = (state == S_SUSPEND);
        win_open  = (state == S_SECT_WIN);
        mode_read = !(mode_id || busy || suspended || win_open);
        if (mode_id && !id_sel[1])
            id_byte = id_sel[0] ? DEV_CODE : MFR_CODE;
        else
            id_byte = 8'h00;
    end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int AW = 19,
    parameter int NS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pgm_req,
    input logic [AW-1:0] pgm_addr,
    input logic [7:0]    pgm_data,
    input logic          chip_erase_req,
    input logic          sect_erase_req,
    input logic [NS-1:0] sect_mask,
    input logic          win_open,
    input logic          mode_read,
    input logic          mode_id,
    input logic          busy,
    input logic          suspended,
    input logic [7:0]    id_byte
);
    p_mode_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_read, mode_id, busy, suspended, win_open}));

    p_req_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_req, chip_erase_req, sect_erase_req}));

    p_pgm_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> busy);

    p_pgm_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |=> !pgm_req);

    p_chip_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_req |-> (&sect_mask && busy));

    p_sect_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_req |-> ((|sect_mask) && busy));

    p_win_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_open) |-> (sect_erase_req || mode_read));

    p_id_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_id |-> (id_byte == 8'h00));

    p_pgm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pgm_addr) && $stable(pgm_data)));
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .NS(NS)) u_fcd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .pgm_req        (pgm_req),
    .pgm_addr       (pgm_addr),
    .pgm_data       (pgm_data),
    .chip_erase_req (chip_erase_req),
    .sect_erase_req (sect_erase_req),
    .sect_mask      (sect_mask),
    .win_open       (win_open),
    .mode_read      (mode_read),
    .mode_id        (mode_id),
    .busy           (busy),
    .suspended      (suspended),
    .id_byte        (id_byte)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  id_sel = '0;
    logic        op_done = 1'b0;
    logic        op_fail = 1'b0;
    logic        pgm_req, chip_erase_req, sect_erase_req;
    logic [18:0] pgm_addr;
    logic [7:0]  pgm_data, id_byte;
    logic [7:0]  sect_mask;
    logic        win_open, mode_read, mode_id, busy, suspended;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder #(.WIN_CYCLES(WIN)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .id_sel(id_sel), .op_done(op_done), .op_fail(op_fail),
        .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
        .sect_mask(sect_mask), .win_open(win_open), .mode_read(mode_read),
        .mode_id(mode_id), .busy(busy), .suspended(suspended), .id_byte(id_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Caller stands at a negedge; the write is taken on the next posedge.
    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic keys();
        wr(19'h3_F555, 8'hAA);
        wr(19'h6_02AA, 8'h55);
    endtask

    task automatic pulse_done();
        op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    endtask

    task automatic erase_prefix();
        keys(); wr(19'h0_0555, 8'h80); keys();
    endtask

    task automatic t_reset();
        chk("R1 mode_read", mode_read, 1);
        chk("R1 flags", {mode_id, busy, suspended, win_open}, 0);
        chk("R1 requests", {pgm_req, chip_erase_req, sect_erase_req}, 0);
        chk("R1 mask", sect_mask, 0);
    endtask

    task automatic t_program();
        keys(); wr(19'h7_F555, 8'hA0); wr(19'h1_2345, 8'h5A);
        chk("R2 pgm_req", pgm_req, 1);
        chk("R2 pgm_addr", pgm_addr, 19'h1_2345);
        chk("R2 pgm_data", pgm_data, 8'h5A);
        chk("R2 busy", busy, 1);
        wr(19'h0, 8'hF0);
        chk("R2 pulse width", pgm_req, 0);
        chk("R9 reset ignored", busy, 1);
        keys();
        chk("R9 keys ignored", busy, 1);
        chk("R9 addr held", pgm_addr, 19'h1_2345);
        pulse_done();
        chk("R9 done to read", mode_read, 1);
    endtask

    task automatic t_abort();
        wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55);
        wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(19'h100, 8'h11);
        chk("R8 bad address", {pgm_req, busy}, 0);
        keys(); wr(19'h555, 8'h77);
        wr(19'h100, 8'h11);
        chk("R8 bad code", {pgm_req, busy}, 0);
        keys(); wr(19'h555, 8'hA0); wr(19'h100, 8'hF0);
        chk("R8 reset in setup", mode_read, 1);
        wr(19'h100, 8'h22);
        chk("R8 no program", {pgm_req, busy}, 0);
    endtask

    task automatic t_ident();
        keys(); wr(19'h555, 8'h90);
        chk("R7 mode_id", mode_id, 1);
        id_sel = 2'b00; #1;
        chk("R7 maker byte", id_byte, 8'hC2);
        id_sel = 2'b01; #1;
        chk("R7 device byte", id_byte, 8'h4F);
        id_sel = 2'b10; #1;
        chk("R7 A1 high", id_byte, 8'h00);
        @(negedge clk);
        keys();
        chk("R7 other writes ignored", mode_id, 1);
        wr(19'h0, 8'hF0);
        chk("R7 reset leaves", {mode_read, mode_id}, 2'b10);
        id_sel = 2'b00; #1;
        chk("R7 byte outside mode", id_byte, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_sector();
        erase_prefix(); wr(19'h2_1234, 8'h30);
        chk("R4 window open", win_open, 1);
        chk("R4 first sector", sect_mask, 8'h04);
        repeat (WIN - 1) @(negedge clk);
        wr(19'h5_0000, 8'h30);
        chk("R5 last-edge load", sect_mask, 8'h24);
        chk("R5 still open", win_open, 1);
        wr(19'h0, 8'hB0);
        chk("R5 B0 ignored", {win_open, sect_mask}, {1'b1, 8'h24});
        repeat (WIN - 2) @(negedge clk);
        chk("R5 not yet expired", {win_open, sect_erase_req}, 2'b10);
        @(negedge clk);
        chk("R5 erase request", {sect_erase_req, busy}, 2'b11);
        pulse_done();
        chk("R5 done", mode_read, 1);
    endtask

    task automatic t_cancel();
        erase_prefix(); wr(19'h7_0000, 8'h30);
        chk("R4 mask cleared on new sequence", sect_mask, 8'h80);
        wr(19'h555, 8'h80);
        chk("R6 cancel", {mode_read, win_open}, 2'b10);
        repeat (WIN + 2) @(negedge clk);
        chk("R6 no erase", busy, 0);
    endtask

    task automatic t_suspend();
        erase_prefix(); wr(19'h4_0555, 8'h10);
        chk("R3 chip request", {chip_erase_req, busy}, 2'b11);
        chk("R3 all sectors", sect_mask, 8'hFF);
        wr(19'h0, 8'h30);
        chk("R10 30h ignored while erasing", {busy, suspended}, 2'b10);
        wr(19'h0, 8'hB0);
        chk("R10 suspend", {busy, suspended}, 2'b01);
        wr(19'h0, 8'hF0);
        chk("R10 reset ignored while held", suspended, 1);
        pulse_done();
        chk("R11 done ignored while held", suspended, 1);
        wr(19'h0, 8'h30);
        chk("R10 resume", {busy, suspended}, 2'b10);
        op_done = 1'b1;
        wr(19'h0, 8'hB0);
        op_done = 1'b0;
        chk("R11 done beats suspend", {mode_read, suspended}, 2'b10);
    endtask

    task automatic t_fail();
        keys(); wr(19'h555, 8'hA0); wr(19'h300, 8'h00);
        op_fail = 1'b1; @(negedge clk); op_fail = 1'b0;
        chk("R12 busy after fail", busy, 1);
        wr(19'h555, 8'hAA);
        chk("R12 other write ignored", busy, 1);
        wr(19'h0, 8'hF0);
        chk("R12 reset clears", mode_read, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_abort();
        t_ident();
        t_sector();
        t_cancel();
        t_suspend();
        t_fail();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule